// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block counts hardware events for a cache-coherence agent. It holds sixteen 48-bit counters. Each counter is steered to one line of a wide event-pulse input vector by an 8-bit code. Counting is gated at two levels. A global run bit starts and stops every counter at once. A per-counter enable bitmap then decides which counters take part.

When a counter wraps past its top value, it raises a sticky overflow flag for that counter. Overflow flags that are not masked are ORed onto a single level interrupt. Software clears a flag by writing a one to its bit in a separate clear register.

All state sits behind a simple 32-bit register port: a write strobe, a byte address, write data, and combinational read data. Each counter appears as a 64-bit slot, accessed as two 32-bit halves.

Top module: `uncore_evt_counter`

## Requirements
- R1: After reset every counter reads zero, the run register (0x1E00) reads 0, the enable register (0x1E04) reads 0, the mask register (0x804) reads 0x0000FFFF, all four select words (0x1E80..0x1E8C) read 0xFFFFFFFF, the status register (0x808) reads 0 and `irq` is low.
- R2: Counter n occupies the 8-byte slot at 0x1F00 + 8*n. The word at +0 holds bits 31:0. The word at +4 holds bits 47:32 in its bits 15:0. Bits 31:16 of the +4 word read as zero, and writes to them are ignored.
- R3: The code for counter n is held in the select word at 0x1E80 + 4*(n/4), bits 8*(n%4)+7 down to 8*(n%4). It reads back as written.
- R4: Counter n adds exactly one on each clock edge where all four of these hold: bit 0 of 0x1E00 is 1, bit n of 0x1E04 is 1, its code is not 0xFF, and `ev_in[code]` is high.
- R5: A counter whose code is 0xFF never counts, even while `ev_in[255]` is high.
- R6: While bit 0 of 0x1E00 is 0, no counter changes except by a software write, and each keeps its value.
- R7: When counter n steps from 2^48-1 to 0, bit n of the status register (0x808) becomes 1 and stays 1 until cleared.
- R8: `irq` is high exactly when some status bit n is 1 while mask bit n (0x804) is 0. A mask bit of 1 blocks that counter.
- R9: Writing 1 to bit n of 0x80C clears status bit n. Zero bits in that write leave status untouched. Writes to 0x808 itself are ignored.
- R10: If an overflow and a clear hit the same status bit in one cycle, the bit ends up set.
- R11: A software write to a counter half in the same cycle as a qualifying event stores the written value, and no increment is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 13 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ev_in | input | 256 | Event pulse lines, indexed by event code |
| irq | output | 1 | Level interrupt: any unmasked overflow flag |

## Verification
The hardest situation to reach is an overflow and a clear landing on the same status bit in the same cycle. A counter needs 2^48 events to wrap on its own, so the stimulus first writes both halves of the counter to just below the top value. It then raises the counter's event line in the same cycle that it writes the clear register. The same preloading technique reaches the wrap itself. It also reaches the case where a software write to a counter collides with an incoming event.

// File: rtl/uevc_pkg.sv
package uevc_pkg;
   // byte offsets of the register windows
   localparam int unsigned OFS_INT_MASK = 32'h0804;
   localparam int unsigned OFS_INT_STAT = 32'h0808;
   localparam int unsigned OFS_INT_CLR  = 32'h080C;
   localparam int unsigned OFS_RUN      = 32'h1E00;
   localparam int unsigned OFS_CNT_EN   = 32'h1E04;
   localparam int unsigned OFS_SEL0     = 32'h1E80;
   localparam int unsigned OFS_CNT0     = 32'h1F00;
   localparam int unsigned LANES_PER_WORD = 4;
   localparam int unsigned LANE_W         = 8;
   localparam int unsigned SLOT_BYTES     = 8;
endpackage

// File: rtl/uevc_counter.sv
module uevc_counter #(
   parameter int CNT_W  = 48,
   parameter int CODE_W = 8,
   parameter int NUM_EV = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [CODE_W-1:0] code,
   input  logic [NUM_EV-1:0] ev,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [31:0]       wdata,
   output logic [CNT_W-1:0]  value,
   output logic              wrap
);
   localparam int HI_W = CNT_W - 32;
   localparam logic [CODE_W-1:0] CODE_NONE = '1;

   logic hit, inc, sw_wr;
   logic unused_wdata;

   assign unused_wdata = &{1'b0, wdata[31:HI_W]};
   assign sw_wr = wr_lo | wr_hi;
   assign hit   = active && (code != CODE_NONE) && ev[code];
   assign inc   = hit && !sw_wr;
   assign wrap  = inc && (&value);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (sw_wr) begin
         if (wr_lo) value[31:0]      <= wdata;
         if (wr_hi) value[CNT_W-1:32] <= wdata[HI_W-1:0];
      end else if (inc) begin
         value <= value + 1'b1;
      end
   end

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> (value == $past(value) || value == $past(value) + 1'b1));
   // R5
   none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && code == CODE_NONE) |=> $stable(value));
   // R6
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && !active) |=> $stable(value));
   // R7
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (value == '0));
   // R11
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (value[31:0] == $past(wdata)));
endmodule

// File: rtl/uevc_ctrl_regs.sv
module uevc_ctrl_regs
   import uevc_pkg::*;
#(
   parameter int NUM_CNT = 16,
   parameter int CODE_W  = 8,
   parameter int WADDR_W = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [WADDR_W-1:0]         waddr,
   input  logic [31:0]                wdata,
   input  logic [NUM_CNT-1:0]         ovf,
   output logic                       run,
   output logic [NUM_CNT-1:0]         cnt_en,
   output logic [NUM_CNT-1:0]         int_mask,
   output logic [NUM_CNT-1:0]         int_stat,
   output logic [NUM_CNT*CODE_W-1:0]  codes,
   output logic                       irq
);
   localparam int NUM_SEL = NUM_CNT / LANES_PER_WORD;
   localparam logic [WADDR_W-1:0] W_MASK = WADDR_W'(OFS_INT_MASK >> 2);
   localparam logic [WADDR_W-1:0] W_CLR  = WADDR_W'(OFS_INT_CLR >> 2);
   localparam logic [WADDR_W-1:0] W_RUN  = WADDR_W'(OFS_RUN >> 2);
   localparam logic [WADDR_W-1:0] W_EN   = WADDR_W'(OFS_CNT_EN >> 2);
   localparam logic [WADDR_W-1:0] W_SEL0 = WADDR_W'(OFS_SEL0 >> 2);

   logic [NUM_CNT-1:0] clr_bits;
   logic unused_wdata;

   assign unused_wdata = &{1'b0, wdata};
   assign clr_bits = (we && waddr == W_CLR) ? wdata[NUM_CNT-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         cnt_en   <= '0;
         int_mask <= '1;
         int_stat <= '0;
      end else begin
         if (we && waddr == W_RUN)  run      <= wdata[0];
         if (we && waddr == W_EN)   cnt_en   <= wdata[NUM_CNT-1:0];
         if (we && waddr == W_MASK) int_mask <= wdata[NUM_CNT-1:0];
         // overflow set is applied after clear so it wins
         int_stat <= (int_stat & ~clr_bits) | ovf;
      end
   end

   for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
      for (genvar k = 0; k < LANES_PER_WORD; k++) begin : g_lane
         localparam int IDX = s * LANES_PER_WORD + k;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               codes[IDX*CODE_W +: CODE_W] <= '1;
            else if (we && waddr == W_SEL0 + WADDR_W'(s))
               codes[IDX*CODE_W +: CODE_W] <= wdata[k*LANE_W +: CODE_W];
         end
      end
   end

   assign irq = |(int_stat & ~int_mask);

   // R7 R10
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf != '0) |=> ((int_stat & $past(ovf)) == $past(ovf)));
   // R9
   clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits != '0) |=> ((int_stat & $past(clr_bits & ~ovf)) == '0));
   // R9
   stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_bits == '0) |=> ((int_stat & $past(int_stat)) == $past(int_stat)));
endmodule

// File: rtl/uncore_evt_counter.sv
module uncore_evt_counter
   import uevc_pkg::*;
#(
   parameter int NUM_CNT = 16,
   parameter int CNT_W   = 48,
   parameter int CODE_W  = 8,
   parameter int ADDR_W  = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [31:0]            reg_wdata,
   output logic [31:0]            reg_rdata,
   input  logic [(2**CODE_W)-1:0] ev_in,
   output logic                   irq
);
   localparam int NUM_EV  = 2 ** CODE_W;
   localparam int WADDR_W = ADDR_W - 2;
   localparam int HI_W    = CNT_W - 32;
   localparam int NUM_SEL = NUM_CNT / LANES_PER_WORD;
   localparam logic [WADDR_W-1:0] W_MASK = WADDR_W'(OFS_INT_MASK >> 2);
   localparam logic [WADDR_W-1:0] W_STAT = WADDR_W'(OFS_INT_STAT >> 2);
   localparam logic [WADDR_W-1:0] W_RUN  = WADDR_W'(OFS_RUN >> 2);
   localparam logic [WADDR_W-1:0] W_EN   = WADDR_W'(OFS_CNT_EN >> 2);
   localparam logic [WADDR_W-1:0] W_SEL0 = WADDR_W'(OFS_SEL0 >> 2);
   localparam logic [WADDR_W-1:0] W_CNT0 = WADDR_W'(OFS_CNT0 >> 2);

   if (NUM_CNT < 1 || NUM_CNT > 32 || (NUM_CNT % LANES_PER_WORD) != 0) begin : g_bad_cnt
      $error("NUM_CNT must be a multiple of 4 between 4 and 32");
   end
   if (CNT_W <= 32 || CNT_W > 64) begin : g_bad_w
      $error("CNT_W must lie in 33..64");
   end
   if (CODE_W < 1 || CODE_W > LANE_W) begin : g_bad_code
      $error("CODE_W must fit one byte lane");
   end
   if (OFS_CNT0 + NUM_CNT * SLOT_BYTES > 2 ** ADDR_W) begin : g_bad_addr
      $error("ADDR_W too small for counter window");
   end

   logic [WADDR_W-1:0]        waddr;
   logic                      run;
   logic [NUM_CNT-1:0]        cnt_en, int_mask, int_stat, ovf;
   logic [NUM_CNT*CODE_W-1:0] codes;
   logic [CNT_W-1:0]          cnt_val [NUM_CNT];
   logic                      unused_addr;

   assign waddr       = reg_addr[ADDR_W-1:2];
   assign unused_addr = &{1'b0, reg_addr[1:0]};

   uevc_ctrl_regs #(.NUM_CNT(NUM_CNT), .CODE_W(CODE_W), .WADDR_W(WADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .waddr   (waddr),
      .wdata   (reg_wdata),
      .ovf     (ovf),
      .run     (run),
      .cnt_en  (cnt_en),
      .int_mask(int_mask),
      .int_stat(int_stat),
      .codes   (codes),
      .irq     (irq)
   );

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      localparam logic [WADDR_W-1:0] W_LO = W_CNT0 + WADDR_W'(2 * g);
      logic wr_lo, wr_hi;
      assign wr_lo = reg_we && waddr == W_LO;
      assign wr_hi = reg_we && waddr == W_LO + 1'b1;
      uevc_counter #(.CNT_W(CNT_W), .CODE_W(CODE_W), .NUM_EV(NUM_EV)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .active(run & cnt_en[g]),
         .code  (codes[g*CODE_W +: CODE_W]),
         .ev    (ev_in),
         .wr_lo (wr_lo),
         .wr_hi (wr_hi),
         .wdata (reg_wdata),
         .value (cnt_val[g]),
         .wrap  (ovf[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (waddr == W_MASK) reg_rdata[NUM_CNT-1:0] = int_mask;
      if (waddr == W_STAT) reg_rdata[NUM_CNT-1:0] = int_stat;
      if (waddr == W_RUN)  reg_rdata[0]           = run;
      if (waddr == W_EN)   reg_rdata[NUM_CNT-1:0] = cnt_en;
      for (int s = 0; s < NUM_SEL; s++) begin
         if (waddr == W_SEL0 + WADDR_W'(s)) begin
            for (int k = 0; k < LANES_PER_WORD; k++)
               reg_rdata[k*LANE_W +: CODE_W] = codes[(s*LANES_PER_WORD+k)*CODE_W +: CODE_W];
         end
      end
      for (int c = 0; c < NUM_CNT; c++) begin
         if (waddr == W_CNT0 + WADDR_W'(2 * c))
            reg_rdata = cnt_val[c][31:0];
         if (waddr == W_CNT0 + WADDR_W'(2 * c + 1))
            reg_rdata[HI_W-1:0] = cnt_val[c][CNT_W-1:32];
      end
   end

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_stat == '0) |-> !irq);
   // R1
   rst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (int_mask == '1));
endmodule

// File: tb/test_uncore_evt_counter.sv
`timescale 1ns/100ps
module test_uncore_evt_counter;
   localparam int KWR = 0, KRD = 1, KEV = 2, KIRQ = 3;
   typedef struct packed {
      logic [1:0]  kind;
      logic [15:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;
   localparam int NV = 49;
   localparam vec_t TBL [NV] = '{
      '{2'd1, 16'h1E00, 32'h0, 32'h00000000, 8'd1},  // R1 run off
      '{2'd1, 16'h1E04, 32'h0, 32'h00000000, 8'd1},  // R1 enables
      '{2'd1, 16'h0804, 32'h0, 32'h0000FFFF, 8'd1},  // R1 mask
      '{2'd1, 16'h1E80, 32'h0, 32'hFFFFFFFF, 8'd1},  // R1 select
      '{2'd1, 16'h1E8C, 32'h0, 32'hFFFFFFFF, 8'd1},  // R1 select
      '{2'd1, 16'h1F00, 32'h0, 32'h00000000, 8'd1},  // R1 counter
      '{2'd1, 16'h0808, 32'h0, 32'h00000000, 8'd1},  // R1 status
      '{2'd0, 16'h1E80, 32'h0A070503, 32'h0, 8'd3},  // R3 codes c0..c3
      '{2'd1, 16'h1E80, 32'h0, 32'h0A070503, 8'd3},  // R3 readback
      '{2'd0, 16'h1E84, 32'hFFFFFF20, 32'h0, 8'd3},  // R3 c4 code 0x20
      '{2'd0, 16'h1E04, 32'h0000001F, 32'h0, 8'd4},  // R4 enable c0..c4
      '{2'd0, 16'h1E00, 32'h1, 32'h0, 8'd4},         // R4 run
      '{2'd2, 16'h0, 32'd3, 32'd5, 8'd4},            // R4 ev3 x5
      '{2'd2, 16'h0, 32'd7, 32'd2, 8'd4},            // R4 ev7 x2
      '{2'd2, 16'h0, 32'h20, 32'd4, 8'd4},           // R4 ev0x20 x4
      '{2'd1, 16'h1F00, 32'h0, 32'd5, 8'd4},         // R4 c0
      '{2'd1, 16'h1F10, 32'h0, 32'd2, 8'd3},         // R3 c2 slot
      '{2'd1, 16'h1F08, 32'h0, 32'd0, 8'd4},         // R4 c1 idle
      '{2'd1, 16'h1F20, 32'h0, 32'd4, 8'd3},         // R3 c4 slot
      '{2'd0, 16'h1E04, 32'h0000FFFF, 32'h0, 8'd5},  // R5 enable all
      '{2'd2, 16'h0, 32'd255, 32'd3, 8'd5},          // R5 ev255 x3
      '{2'd1, 16'h1F28, 32'h0, 32'd0, 8'd5},         // R5 c5
      '{2'd1, 16'h1F78, 32'h0, 32'd0, 8'd5},         // R5 c15
      '{2'd0, 16'h1E00, 32'h0, 32'h0, 8'd6},         // R6 stop
      '{2'd2, 16'h0, 32'd3, 32'd6, 8'd6},            // R6 ev3 x6
      '{2'd1, 16'h1F00, 32'h0, 32'd5, 8'd6},         // R6 held
      '{2'd0, 16'h1F04, 32'hABCD1234, 32'h0, 8'd2},  // R2 high write
      '{2'd1, 16'h1F04, 32'h0, 32'h00001234, 8'd2},  // R2 upper RAZ
      '{2'd1, 16'h1F00, 32'h0, 32'd5, 8'd2},         // R2 low intact
      '{2'd0, 16'h1F0C, 32'h0000FFFF, 32'h0, 8'd7},  // R7 preload
      '{2'd0, 16'h1F08, 32'hFFFFFFFE, 32'h0, 8'd7},  // R7 preload
      '{2'd0, 16'h1E00, 32'h1, 32'h0, 8'd7},         // R7 run
      '{2'd2, 16'h0, 32'd5, 32'd1, 8'd7},            // R7 to max
      '{2'd1, 16'h0808, 32'h0, 32'd0, 8'd7},         // R7 no flag yet
      '{2'd2, 16'h0, 32'd5, 32'd1, 8'd7},            // R7 wrap
      '{2'd1, 16'h0808, 32'h0, 32'd2, 8'd7},         // R7 flag c1
      '{2'd1, 16'h1F08, 32'h0, 32'd0, 8'd7},         // R7 low zero
      '{2'd1, 16'h1F0C, 32'h0, 32'd0, 8'd7},         // R7 high zero
      '{2'd3, 16'h0, 32'h0, 32'd0, 8'd8},            // R8 masked
      '{2'd0, 16'h0804, 32'h0000FFFD, 32'h0, 8'd8},  // R8 unmask c1
      '{2'd3, 16'h0, 32'h0, 32'd1, 8'd8},            // R8 irq
      '{2'd0, 16'h0804, 32'h0000FFFF, 32'h0, 8'd8},  // R8 remask
      '{2'd3, 16'h0, 32'h0, 32'd0, 8'd8},            // R8 quiet
      '{2'd0, 16'h0808, 32'h0, 32'h0, 8'd9},         // R9 status write
      '{2'd1, 16'h0808, 32'h0, 32'd2, 8'd9},         // R9 ignored
      '{2'd0, 16'h080C, 32'h0000FFFD, 32'h0, 8'd9},  // R9 other bits
      '{2'd1, 16'h0808, 32'h0, 32'd2, 8'd9},         // R9 kept
      '{2'd0, 16'h080C, 32'h00000002, 32'h0, 8'd9},  // R9 clear c1
      '{2'd1, 16'h0808, 32'h0, 32'd0, 8'd9}          // R9 cleared
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [12:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [255:0] ev_in = '0;
   logic        irq;
   int n_chk = 0, n_bad = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   uncore_evt_counter i_uncore_evt_counter (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in), .irq(irq));

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: got %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a[12:0]; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b0; reg_addr = a[12:0];
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input int idx, input int cycles);
      @(negedge clk);
      ev_in[idx] = 1'b1;
      repeat (cycles) @(posedge clk);
      @(negedge clk);
      ev_in = '0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check(1, {31'd0, irq}, 32'd0);  // R1 irq low
      for (int i = 0; i < NV; i++) begin
         case (int'(TBL[i].kind))
            KWR:  wr(TBL[i].addr, TBL[i].data);
            KRD:  begin rd(TBL[i].addr, v); check(int'(TBL[i].req), v, TBL[i].exp); end
            KEV:  pulse(int'(TBL[i].data), int'(TBL[i].exp));
            KIRQ: begin @(negedge clk); #1 check(int'(TBL[i].req), {31'd0, irq}, TBL[i].exp); end
            default: ;
         endcase
      end
      // R11: write collides with event on counter 0 (code 3), run is on
      @(negedge clk);
      ev_in[3] = 1'b1; reg_we = 1'b1; reg_addr = 13'h1F00; reg_wdata = 32'd100;
      @(negedge clk);
      ev_in = '0; reg_we = 1'b0;
      rd(16'h1F00, v); check(11, v, 32'd100);
      // R10: wrap of counter 1 coincides with clear of its flag
      wr(16'h1F0C, 32'h0000FFFF);
      wr(16'h1F08, 32'hFFFFFFFF);
      @(negedge clk);
      ev_in[5] = 1'b1; reg_we = 1'b1; reg_addr = 13'h080C; reg_wdata = 32'd2;
      @(negedge clk);
      ev_in = '0; reg_we = 1'b0;
      rd(16'h0808, v); check(10, v, 32'd2);
      rd(16'h1F08, v); check(10, v, 32'd0);
      // R8: flag still masked
      @(negedge clk); #1 check(8, {31'd0, irq}, 32'd0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule